// File: doc/BRIEF.md
# Fixed-Latency Memory Channel Model

This block stands in for a memory channel shared by several cache sub-partitions whenever real device timing is not wanted. Each sub-partition shows the head of its outbound request queue: a valid bit, a request tag and a flag marking the request as a write-back. A rotating arbiter accepts at most one request per cycle. It stamps the request with a maturity time, which is the free-running cycle count plus a fixed latency, and appends it to an in-order latency FIFO.

Only the oldest entry can leave, and only after it has matured. A matured read is handed back to the return queue of the sub-partition that issued it. A matured write-back is reported as done and produces no reply. If the target return queue is full, the read at the head waits, and everything behind it waits too.

Every sub-partition holds a small pool of issue credits. One credit is spent at each grant and comes back when that request retires. This bounds how many requests each source can have in flight.

Top module: `fixlat_mem_channel`

## Requirements
- R1: The arbiter scans sub-partitions starting one index past the last granted index, wrapping modulo NUM_SP. The pointer moves only on a grant. After reset it holds NUM_SP-1, so index 0 is examined first.
- R2: At most one bit of `req_pop` is high in any cycle.
- R3: A sub-partition can be granted only while its `req_valid` is high and it holds at least one credit. Every pool starts at MAX_CREDIT after reset.
- R4: While the latency FIFO holds FIFO_DEPTH entries, no request is granted, even if some are eligible.
- R5: Suppose a request is granted in the cycle in which the internal count equals c, where the count is 0 in the first cycle after reset and increases by one each cycle. That request cannot retire before the cycle whose count is c+LATENCY. If the head is not blocked, it retires in exactly that cycle.
- R6: A matured write-back head (`req_wb`=1 at grant) raises `done_valid` for one cycle with its tag on `out_id` and its source on `out_sp`. No bit of `ret_push` is raised.
- R7: A matured read head whose source `ret_full` bit is low raises only `ret_push[sp]`, with its tag on `out_id` and `sp` on `out_sp`.
- R8: While the matured head is a read whose source `ret_full` bit is high, nothing retires. Entries always retire in grant order.
- R9: A credit is spent at each grant and returned when that request retires, whether as a reply or as a write-back. A sub-partition never has more than MAX_CREDIT requests outstanding.
- R10: During reset and in the first cycle after it, no reply and no done indication is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_SP | Request queue of each sub-partition is non-empty |
| req_id | input | NUM_SP*ID_W | Head tag of each sub-partition, index i at bits [i*ID_W +: ID_W] |
| req_wb | input | NUM_SP | Head of each sub-partition is a write-back |
| req_pop | output | NUM_SP | One-hot grant: pops that sub-partition's request queue this cycle |
| ret_full | input | NUM_SP | Return queue of each sub-partition is full |
| ret_push | output | NUM_SP | Pushes the reply on `out_id` into that sub-partition's return queue |
| done_valid | output | 1 | A write-back retired this cycle |
| out_id | output | ID_W | Tag of the retiring entry |
| out_sp | output | SP_W | Source sub-partition of the retiring entry |

## Verification
A grant appears on `req_pop` combinationally, in the same cycle as the `req_valid` pattern that causes it. The granted entry becomes visible on the retire outputs exactly LATENCY cycles later, unless a full return queue holds the head back. A returned credit affects eligibility from the following cycle.

The bench drives its inputs on the falling clock edge and reads the outputs 1 ns later. Each cycle it compares all outputs with a behavioural queue model that is advanced once per cycle, so every result is checked in the cycle it is due. Directed sequences also measure the read latency, the credit ceiling and blocking on a full FIFO.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
    localparam int CYC_W = 64;
    typedef logic [CYC_W-1:0] cycle_t;

    typedef enum logic [1:0] {
        RT_IDLE    = 2'd0,
        RT_REPLY   = 2'd1,
        RT_WRBACK  = 2'd2,
        RT_BLOCKED = 2'd3
    } retire_e;
endpackage

// File: rtl/fmc_rr_arbiter.sv
module fmc_rr_arbiter #(
    parameter int NUM_SP = 4,
    parameter int SP_W   = (NUM_SP > 1) ? $clog2(NUM_SP) : 1
) (
    input  logic [SP_W-1:0]   last_grant,
    input  logic [NUM_SP-1:0] eligible,
    input  logic              block,
    output logic [NUM_SP-1:0] grant,
    output logic [SP_W-1:0]   grant_idx,
    output logic              grant_valid
);
    always_comb begin
        logic found;
        found       = 1'b0;
        grant       = '0;
        grant_idx   = '0;
        grant_valid = 1'b0;
        for (int k = 1; k <= NUM_SP; k++) begin
            int idx;
            idx = (int'(last_grant) + k) % NUM_SP;
            if (!found && eligible[idx]) begin
                found = 1'b1;
                if (!block) begin
                    grant[idx]  = 1'b1;
                    grant_idx   = SP_W'(idx);
                    grant_valid = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fmc_credit_bank.sv
module fmc_credit_bank #(
    parameter int NUM_SP     = 4,
    parameter int MAX_CREDIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SP-1:0] take,
    input  logic [NUM_SP-1:0] give,
    output logic [NUM_SP-1:0] avail
);
    localparam int CR_W = $clog2(MAX_CREDIT + 1);

    for (genvar g = 0; g < NUM_SP; g++) begin : g_pool
        logic [CR_W-1:0] cred_d, cred_q;

        always_comb begin
            cred_d = cred_q;
            if (take[g] && !give[g]) begin
                cred_d = cred_q - CR_W'(1);
            end else if (give[g] && !take[g]) begin
                cred_d = cred_q + CR_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cred_q <= CR_W'(MAX_CREDIT);
            end else begin
                cred_q <= cred_d;
            end
        end

        assign avail[g] = (cred_q != '0);
    end
endmodule

// File: rtl/fmc_latency_fifo.sv
module fmc_latency_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         head_valid,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];
    logic         push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full       = (ctl_q.cnt == CNT_W'(DEPTH));
    assign head_valid = (ctl_q.cnt != '0);
    assign head_data  = mem_q[ctl_q.rd];
    assign push_ok    = push && !full;
    assign pop_ok     = pop && head_valid;

    always_comb begin
        ctl_d = ctl_q;
        mem_d = mem_q;
        if (push_ok) begin
            mem_d[ctl_q.wr] = push_data;
            ctl_d.wr        = wrap_inc(ctl_q.wr);
        end
        if (pop_ok) begin
            ctl_d.rd = wrap_inc(ctl_q.rd);
        end
        ctl_d.cnt = ctl_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/fixlat_mem_channel.sv
module fixlat_mem_channel
    import fmc_pkg::*;
#(
    parameter int  NUM_SP     = 4,
    parameter int  ID_W       = 8,
    parameter int  LATENCY    = 6,
    parameter int  FIFO_DEPTH = 4,
    parameter int  MAX_CREDIT = 2,
    localparam int SP_W       = (NUM_SP > 1) ? $clog2(NUM_SP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SP-1:0]      req_valid,
    input  logic [NUM_SP*ID_W-1:0] req_id,
    input  logic [NUM_SP-1:0]      req_wb,
    output logic [NUM_SP-1:0]      req_pop,
    input  logic [NUM_SP-1:0]      ret_full,
    output logic [NUM_SP-1:0]      ret_push,
    output logic                   done_valid,
    output logic [ID_W-1:0]        out_id,
    output logic [SP_W-1:0]        out_sp
);
    typedef struct packed {
        cycle_t          ready;
        logic [ID_W-1:0] id;
        logic [SP_W-1:0] sp;
        logic            wb;
    } entry_t;

    localparam int ENT_W = $bits(entry_t);

    typedef struct packed {
        cycle_t          cyc;
        logic [SP_W-1:0] last;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    logic [NUM_SP-1:0] credit_avail, credit_give, eligible;
    logic [NUM_SP-1:0] grant;
    logic [SP_W-1:0]   grant_idx;
    logic              grant_valid;
    logic              fifo_full, head_valid, head_pop;
    entry_t            new_ent, head_ent;
    logic [ENT_W-1:0]  head_raw;
    retire_e           ret_act;

    assign eligible = req_valid & credit_avail;

    fmc_rr_arbiter #(.NUM_SP(NUM_SP), .SP_W(SP_W)) u_arb (
        .last_grant (st_q.last),
        .eligible   (eligible),
        .block      (fifo_full),
        .grant      (grant),
        .grant_idx  (grant_idx),
        .grant_valid(grant_valid)
    );

    assign req_pop = grant;

    always_comb begin
        new_ent.ready = st_q.cyc + cycle_t'(LATENCY);
        new_ent.id    = req_id[int'(grant_idx)*ID_W +: ID_W];
        new_ent.sp    = grant_idx;
        new_ent.wb    = req_wb[grant_idx];
    end

    fmc_latency_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grant_valid),
        .push_data (new_ent),
        .pop       (head_pop),
        .head_data (head_raw),
        .head_valid(head_valid),
        .full      (fifo_full)
    );

    assign head_ent = entry_t'(head_raw);

    always_comb begin
        ret_act = RT_IDLE;
        if (head_valid && (st_q.cyc >= head_ent.ready)) begin
            if (head_ent.wb) begin
                ret_act = RT_WRBACK;
            end else if (ret_full[head_ent.sp]) begin
                ret_act = RT_BLOCKED;
            end else begin
                ret_act = RT_REPLY;
            end
        end
    end

    always_comb begin
        ret_push    = '0;
        credit_give = '0;
        done_valid  = (ret_act == RT_WRBACK);
        head_pop    = (ret_act == RT_WRBACK) || (ret_act == RT_REPLY);
        if (ret_act == RT_REPLY) begin
            ret_push[head_ent.sp] = 1'b1;
        end
        if (head_pop) begin
            credit_give[head_ent.sp] = 1'b1;
        end
    end

    assign out_id = head_ent.id;
    assign out_sp = head_ent.sp;

    fmc_credit_bank #(.NUM_SP(NUM_SP), .MAX_CREDIT(MAX_CREDIT)) u_cred (
        .clk  (clk),
        .rst_n(rst_n),
        .take (grant),
        .give (credit_give),
        .avail(credit_avail)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + cycle_t'(1);
        if (grant_valid) begin
            st_d.last = grant_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cyc  <= '0;
            st_q.last <= SP_W'(NUM_SP - 1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker #(
    parameter int NUM_SP     = 4,
    parameter int MAX_CREDIT = 2,
    parameter int SP_W       = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SP-1:0] req_valid,
    input logic [NUM_SP-1:0] req_pop,
    input logic [NUM_SP-1:0] ret_full,
    input logic [NUM_SP-1:0] ret_push,
    input logic              done_valid,
    input logic [SP_W-1:0]   out_sp,
    input logic              fifo_full
);
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_pop));

    a_r7_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ret_push));

    a_r6_wb_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (ret_push == '0));

    a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (req_pop == '0));

    for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
        int outstanding;
        logic retired;
        assign retired = ret_push[g] || (done_valid && (out_sp == SP_W'(g)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                outstanding <= 0;
            end else begin
                outstanding <= outstanding + int'(req_pop[g]) - int'(retired);
            end
        end

        a_r3_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
            req_pop[g] |-> req_valid[g]);

        a_r3_grant_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
            req_pop[g] |-> (outstanding < MAX_CREDIT));

        a_r9_credit_limit: assert property (@(posedge clk) disable iff (!rst_n)
            (outstanding >= 0) && (outstanding <= MAX_CREDIT));

        a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            ret_push[g] |-> !ret_full[g]);
    end
endmodule

bind fixlat_mem_channel fmc_checker #(
    .NUM_SP    (NUM_SP),
    .MAX_CREDIT(MAX_CREDIT),
    .SP_W      (SP_W)
) u_fmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pop   (req_pop),
    .ret_full  (ret_full),
    .ret_push  (ret_push),
    .done_valid(done_valid),
    .out_sp    (out_sp),
    .fifo_full (fifo_full)
);

// File: tb/tb_fixlat_mem_channel.sv
module tb_fixlat_mem_channel;
    localparam int N   = 4;
    localparam int IDW = 8;
    localparam int LAT = 6;
    localparam int DEP = 4;
    localparam int MC  = 2;
    localparam int SPW = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   req_valid, req_wb, req_pop, ret_full, ret_push;
    logic [N*IDW-1:0] req_id;
    logic           done_valid;
    logic [IDW-1:0] out_id;
    logic [SPW-1:0] out_sp;

    always #10 clk = ~clk;

    fixlat_mem_channel #(
        .NUM_SP(N), .ID_W(IDW), .LATENCY(LAT), .FIFO_DEPTH(DEP), .MAX_CREDIT(MC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_wb(req_wb), .req_pop(req_pop), .ret_full(ret_full),
        .ret_push(ret_push), .done_valid(done_valid), .out_id(out_id), .out_sp(out_sp)
    );

    typedef struct {
        int id;
        int sp;
        bit wb;
        int ready;
    } ment_t;

    ment_t mq[$];
    int    cred[N];
    int    seq[N];
    int    last, cyc;
    int    checks = 0, errors = 0;
    bit    full_seen, stall_seen, wb_seen, cred_block_seen;
    logic [N-1:0] obs_pop, obs_push;
    logic         obs_done;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] v, input logic [N-1:0] wb, input logic [N-1:0] rf);
        logic [N-1:0] e_pop, e_push;
        logic         e_done;
        int           e_id, e_sp, gidx;
        bit           pop_head;
        ment_t        ent;
        req_valid = v;
        req_wb    = wb;
        ret_full  = rf;
        for (int i = 0; i < N; i++) req_id[i*IDW +: IDW] = IDW'(i*64 + (seq[i] % 64));
        #1;
        e_pop = '0; e_push = '0; e_done = 1'b0; e_id = 0; e_sp = 0; gidx = -1; pop_head = 0;
        if (mq.size() > 0 && cyc >= mq[0].ready) begin
            e_id = mq[0].id;
            e_sp = mq[0].sp;
            if (mq[0].wb) begin
                e_done = 1'b1; pop_head = 1; wb_seen = 1;
            end else if (!rf[e_sp]) begin
                e_push[e_sp] = 1'b1; pop_head = 1;
            end else begin
                stall_seen = 1;
            end
        end
        for (int i = 0; i < N; i++) if (v[i] && cred[i] == 0) cred_block_seen = 1;
        if (mq.size() >= DEP) begin
            for (int i = 0; i < N; i++) if (v[i] && cred[i] > 0) full_seen = 1;
        end else begin
            for (int k = 1; k <= N; k++) begin
                int idx;
                idx = (last + k) % N;
                if (gidx < 0 && v[idx] && cred[idx] > 0) begin
                    gidx = idx;
                    e_pop[idx] = 1'b1;
                end
            end
        end
        // R1 R3 R4: grant pattern
        chk(req_pop == e_pop, "R1 grant", req_pop, e_pop);
        chk($countones(req_pop) <= 1, "R2 one grant", $countones(req_pop), 1);
        // R7 R8: reply pattern
        chk(ret_push == e_push, "R7 reply", ret_push, e_push);
        // R6: write-back completion
        chk(done_valid == e_done, "R6 done", done_valid, e_done);
        if (e_done || e_push != '0) begin
            chk(out_id == IDW'(e_id), "R8 order tag", out_id, e_id);
            chk(out_sp == SPW'(e_sp), "R7 source", out_sp, e_sp);
        end
        obs_pop  = req_pop;
        obs_push = ret_push;
        obs_done = done_valid;
        if (pop_head) begin
            cred[e_sp]++;
            void'(mq.pop_front());
        end
        if (gidx >= 0) begin
            ent.id    = gidx*64 + (seq[gidx] % 64);
            ent.sp    = gidx;
            ent.wb    = wb[gidx];
            ent.ready = cyc + LAT;
            mq.push_back(ent);
            cred[gidx]--;
            last = gidx;
            seq[gidx]++;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) step('0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pops;
        rst_n = 1'b0; req_valid = '0; req_wb = '0; ret_full = '0; req_id = '0;
        for (int i = 0; i < N; i++) begin cred[i] = MC; seq[i] = 0; end
        last = N - 1; cyc = 0;
        repeat (3) @(negedge clk);
        // R10: quiet during reset
        chk(ret_push == '0 && !done_valid, "R10 reset", {ret_push, done_valid}, 0);
        rst_n = 1'b1;
        step('0, '0, '0);
        chk(obs_push == '0 && !obs_done, "R10 first cycle", {obs_push, obs_done}, 0);

        // R1: sub-partition 0 examined first, then rotation
        step(4'b1111, '0, '0);
        chk(obs_pop == 4'b0001, "R1 first grant", obs_pop, 4'b0001);
        step(4'b1111, '0, '0);
        chk(obs_pop == 4'b0010, "R1 rotation", obs_pop, 4'b0010);
        drain();

        // R5: exact latency for an unblocked read
        step(4'b0100, '0, '0);
        chk(obs_pop == 4'b0100, "R5 grant", obs_pop, 4'b0100);
        for (int k = 1; k <= LAT; k++) begin
            step('0, '0, '0);
            if (k < LAT) chk(obs_push == '0, "R5 early", obs_push, 0);
            else         chk(obs_push == 4'b0100, "R5 due", obs_push, 4'b0100);
        end
        drain();

        // R9: credit ceiling for a single source with blocked returns
        pops = 0;
        for (int k = 0; k < 20; k++) begin
            step(4'b0001, '0, 4'b0001);
            if (obs_pop[0]) pops++;
        end
        chk(pops == MC, "R9 ceiling", pops, MC);
        drain();

        // R4 R8: all sources blocked, FIFO fills
        for (int k = 0; k < 60; k++) step(4'b1111, '0, 4'b1111);
        drain();

        // Mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] rv, rw, rr;
            rv = N'($urandom);
            rw = N'($urandom);
            rr = (($urandom % 4) == 0) ? N'($urandom) : '0;
            step(rv, rw, rr);
        end
        drain();

        chk(full_seen, "R4 full blocking exercised", full_seen, 1);
        chk(stall_seen, "R8 stall exercised", stall_seen, 1);
        chk(wb_seen, "R6 write-back exercised", wb_seen, 1);
        chk(cred_block_seen, "R3 credit exhaustion exercised", cred_block_seen, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule